// File: doc/BRIEF.md
# SPI Serial Memory Command Interface

This block is the slave-side serial front end of a 1024-byte serial memory. It oversamples the serial clock, chip select and data-in lines in the system clock, assembles each transaction of one command byte, an optional 16-bit address and any number of data bytes, and drives the serial data-out line. Input bits are taken on the rising serial clock edge and output bits change after the falling edge, most significant bit first. Both idle-low and idle-high clock polarities (SPI modes 0 and 3) are handled.

Towards the storage side it offers an asynchronous read port addressed by `mem_addr`. Each complete write byte goes out as a staging pulse carrying its address and data. At deselect the block then either commits the staged page or cancels it. It also issues status-register write requests and one-cycle pulses that set or clear the write-enable latch. Whether a page write or a status write may take effect is decided by a separate protection block and arrives here as two grant inputs. The status byte itself is supplied from outside and is only read here.

The serial clock must be slower than the system clock by a wide margin: each half period of the serial clock must last at least eight system clock cycles.

Top module: `spi_mem_cmd_if`

## Requirements
- R1: After reset, `spi_miso_oe` and `spi_miso` are 0 and no request output pulses.
- R2: After reset, the block accepts no command until `spi_cs_n` has been seen high and then low. Serial clocks sent while chip select is still low from reset cause no request.
- R3: An opcode other than 0x06, 0x04, 0x05, 0x01, 0x03, 0x02 or 0x07 makes the block ignore every further clock until deselect. In that time no request pulses and `spi_miso` stays 0.
- R4: READ (0x03) takes two address bytes, high byte first, and uses only the low 10 bits. The addressed byte is shifted out from the first falling clock after the last address bit. The address then increases by one per byte and wraps from 0x3FF to 0x000.
- R5: RDSR (0x05) returns a status byte every eight clocks for as long as the clock runs. Each byte is the value of `status_in` at the end of the preceding byte.
- R6: WREN (0x06) and WRDI (0x04) each give one single-cycle pulse on `wren_req` or `wrdi_req`. After that, all further bits until deselect are ignored.
- R7: WRITE (0x02) takes a 10-bit address as READ does. Each full data byte gives one `wr_stage` pulse with `wr_addr` and `wr_data`. Between bytes, address bits 4:0 increase and wrap inside the 32-byte page while bits 9:5 stay fixed.
- R8: At deselect after a WRITE that staged at least one byte, `wr_commit` pulses if chip select rose on a byte boundary and `mem_wr_grant` is 1. Otherwise `wr_cancel` pulses. A WRITE that staged no byte produces neither pulse.
- R9: WRINC (0x07) behaves as WRITE, and its commit carries `wr_incr` = 1 (0 for WRITE).
- R10: WRSR (0x01) takes its first data byte. If chip select rises on a byte boundary and `sr_wr_grant` is 1, `sr_wr_req` pulses with that byte on `sr_wr_data`. Later bytes do not change it.
- R11: `spi_miso_oe` is 1 only while a transaction is open, and it drops within a few system cycles after chip select rises.
- R12: Transactions behave identically with the serial clock idling low or idling high.
- R13: At most one of the request outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock (asynchronous) |
| spi_cs_n | input | 1 | Chip select, low active (asynchronous) |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| mem_addr | output | 10 | Read address to storage |
| mem_rd_data | input | 8 | Byte at `mem_addr`, combinational |
| status_in | input | 8 | Current status byte |
| mem_wr_grant | input | 1 | Protection permits the page commit |
| sr_wr_grant | input | 1 | Protection permits the status write |
| wren_req | output | 1 | Set write-enable latch (pulse) |
| wrdi_req | output | 1 | Clear write-enable latch (pulse) |
| wr_stage | output | 1 | One write byte staged (pulse) |
| wr_addr | output | 10 | Address of the staged byte |
| wr_data | output | 8 | Staged byte |
| wr_commit | output | 1 | Program the staged page (pulse) |
| wr_incr | output | 1 | Commit is for the monotonic-counter command |
| wr_cancel | output | 1 | Discard the staged page (pulse) |
| sr_wr_req | output | 1 | Status register write (pulse) |
| sr_wr_data | output | 8 | Value for the status register |

## Verification
A wrong command state shows up at the ports within the next byte. Either a request pulse appears where the scoreboard expects none, or `spi_miso` carries zeros or the wrong memory byte on the first data byte. A bit counter that slips by one shifts every read byte and every staged byte, so the very first data byte after the address exposes it. An error in the page wrap or the commit rule shows up as a staged address or a commit/cancel pulse within a few cycles of the byte or of deselect.

// File: rtl/spi_mem_pkg.sv
// Shared command codes and sequencer states for the serial memory interface.
package spi_mem_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_WRINC = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_SRD, ST_WDAT, ST_SRWR, ST_HALT
    } cmd_state_t;
endpackage

// File: rtl/spi_mem_sync.sv
// Brings the three serial inputs into the clk domain through STAGES flops each
// and produces single-cycle edge pulses for the clock and chip select.
// Assumes the serial clock half period spans several clk cycles. All flops reset
// to 0, so chip select held low through reset never yields a falling edge.
module spi_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall,
    output logic cs_s,
    output logic cs_q,
    output logic mosi_s
);
    localparam int NSIG = 3;
    logic [NSIG-1:0] raw;
    logic [NSIG-1:0][STAGES-1:0] chain;
    logic sck_s, sck_q;

    assign raw = {mosi_in, cs_n_in, sck_in};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        // Shift chain per input signal.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
        end
    end

    assign sck_s  = chain[0][STAGES-1];
    assign cs_s   = chain[1][STAGES-1];
    assign mosi_s = chain[2][STAGES-1];

    // Previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
        end
    end

    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign cs_rise  = cs_s & ~cs_q;
    assign cs_fall  = ~cs_s & cs_q;
endmodule

// File: rtl/spi_mem_seq.sv
// Command sequencer: assembles opcode, address and data bytes from the sampled
// bit stream and issues storage, latch and status requests. Assumes edge pulses
// from spi_mem_sync and a combinational read port on the storage side.
module spi_mem_seq
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              mosi_s,
    input  logic              mem_wr_grant,
    input  logic              sr_wr_grant,
    output logic              sess,
    output logic              tx_en,
    output logic              load_req,
    output logic              load_sts,
    output logic [ADDR_W-1:0] addr,
    output logic              wren_req,
    output logic              wrdi_req,
    output logic              wr_stage,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              wr_incr,
    output logic              wr_cancel,
    output logic              sr_wr_req,
    output logic [7:0]        sr_wr_data
);
    localparam int HI_BITS = ADDR_W - 8;

    cmd_state_t  st;
    logic [2:0]  cnt;
    logic [6:0]  sh;
    logic        addr_hi_done;
    logic        is_wr;
    logic        is_inc;
    logic        have;
    logic [7:0]  nb;

    assign nb    = {sh, mosi_s};
    assign sess  = (st != ST_IDLE);
    assign tx_en = (st == ST_RDAT) || (st == ST_SRD);

    // Transaction state, bit and byte handling, request pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            cnt          <= '0;
            sh           <= '0;
            addr_hi_done <= 1'b0;
            is_wr        <= 1'b0;
            is_inc       <= 1'b0;
            have         <= 1'b0;
            addr         <= '0;
            load_req     <= 1'b0;
            load_sts     <= 1'b0;
            wren_req     <= 1'b0;
            wrdi_req     <= 1'b0;
            wr_stage     <= 1'b0;
            wr_addr      <= '0;
            wr_data      <= '0;
            wr_commit    <= 1'b0;
            wr_incr      <= 1'b0;
            wr_cancel    <= 1'b0;
            sr_wr_req    <= 1'b0;
            sr_wr_data   <= '0;
        end else begin
            load_req  <= 1'b0;
            wren_req  <= 1'b0;
            wrdi_req  <= 1'b0;
            wr_stage  <= 1'b0;
            wr_commit <= 1'b0;
            wr_cancel <= 1'b0;
            sr_wr_req <= 1'b0;
            if (cs_rise) begin
                if (st == ST_WDAT && have) begin
                    if (cnt == 3'd0 && mem_wr_grant) begin
                        wr_commit <= 1'b1;
                        wr_incr   <= is_inc;
                    end else begin
                        wr_cancel <= 1'b1;
                    end
                end
                if (st == ST_SRWR && have && cnt == 3'd0 && sr_wr_grant)
                    sr_wr_req <= 1'b1;
                st <= ST_IDLE;
            end else if (cs_fall) begin
                st           <= ST_OPC;
                cnt          <= '0;
                have         <= 1'b0;
                addr_hi_done <= 1'b0;
            end else if (sck_rise && st != ST_IDLE && st != ST_HALT) begin
                cnt <= cnt + 3'd1;
                sh  <= nb[6:0];
                if (cnt == 3'd7) begin
                    case (st)
                        ST_OPC: begin
                            case (nb)
                                OP_WREN:  begin wren_req <= 1'b1; st <= ST_HALT; end
                                OP_WRDI:  begin wrdi_req <= 1'b1; st <= ST_HALT; end
                                OP_RDSR:  begin st <= ST_SRD; load_req <= 1'b1; load_sts <= 1'b1; end
                                OP_WRSR:  st <= ST_SRWR;
                                OP_READ:  begin st <= ST_ADDR; is_wr <= 1'b0; end
                                OP_WRITE: begin st <= ST_ADDR; is_wr <= 1'b1; is_inc <= 1'b0; end
                                OP_WRINC: begin st <= ST_ADDR; is_wr <= 1'b1; is_inc <= 1'b1; end
                                default:  st <= ST_HALT;
                            endcase
                        end
                        ST_ADDR: begin
                            if (!addr_hi_done) begin
                                addr[ADDR_W-1:8] <= nb[HI_BITS-1:0];
                                addr_hi_done     <= 1'b1;
                            end else begin
                                addr[7:0] <= nb;
                                if (is_wr) begin
                                    st <= ST_WDAT;
                                end else begin
                                    st       <= ST_RDAT;
                                    load_req <= 1'b1;
                                    load_sts <= 1'b0;
                                end
                            end
                        end
                        ST_RDAT: begin
                            addr     <= addr + ADDR_W'(1);
                            load_req <= 1'b1;
                        end
                        ST_SRD: load_req <= 1'b1;
                        ST_WDAT: begin
                            wr_stage <= 1'b1;
                            wr_addr  <= addr;
                            wr_data  <= nb;
                            addr     <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
                            have     <= 1'b1;
                        end
                        ST_SRWR: begin
                            if (!have) begin
                                sr_wr_data <= nb;
                                have       <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/spi_mem_tx.sv
// Output shifter: loads a byte on request and presents one bit per falling
// serial clock edge, MSB first. Assumes a load never coincides with a fall.
module spi_mem_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sess,
    input  logic       tx_en,
    input  logic       sck_fall,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic       miso
);
    logic [7:0] sh;

    // Byte load and falling-edge shift; cleared whenever no transaction is open.
    always_ff @(posedge clk) begin
        if (!rst_n || !sess) begin
            sh   <= '0;
            miso <= 1'b0;
        end else if (load) begin
            sh <= load_byte;
        end else if (sck_fall && tx_en) begin
            miso <= sh[7];
            sh   <= {sh[6:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_mem_cmd_if.sv
// Top of the serial memory command interface: synchronizer, sequencer and
// output shifter. Assumes the storage read port answers combinationally.
module spi_mem_cmd_if #(
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    input  logic [7:0]        status_in,
    input  logic              mem_wr_grant,
    input  logic              sr_wr_grant,
    output logic              wren_req,
    output logic              wrdi_req,
    output logic              wr_stage,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              wr_incr,
    output logic              wr_cancel,
    output logic              sr_wr_req,
    output logic [7:0]        sr_wr_data
);
    logic sck_rise, sck_fall, cs_rise, cs_fall, cs_s, cs_q, mosi_s;
    logic sess, tx_en, load_req, load_sts;

    spi_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_in(spi_sck), .cs_n_in(spi_cs_n),
        .mosi_in(spi_mosi), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_rise(cs_rise), .cs_fall(cs_fall), .cs_s(cs_s), .cs_q(cs_q),
        .mosi_s(mosi_s)
    );

    spi_mem_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_rise(cs_rise),
        .cs_fall(cs_fall), .mosi_s(mosi_s), .mem_wr_grant(mem_wr_grant),
        .sr_wr_grant(sr_wr_grant), .sess(sess), .tx_en(tx_en),
        .load_req(load_req), .load_sts(load_sts), .addr(mem_addr),
        .wren_req(wren_req), .wrdi_req(wrdi_req), .wr_stage(wr_stage),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .wr_incr(wr_incr), .wr_cancel(wr_cancel), .sr_wr_req(sr_wr_req),
        .sr_wr_data(sr_wr_data)
    );

    spi_mem_tx u_tx (
        .clk(clk), .rst_n(rst_n), .sess(sess), .tx_en(tx_en),
        .sck_fall(sck_fall), .load(load_req),
        .load_byte(load_sts ? status_in : mem_rd_data), .miso(spi_miso)
    );

    assign spi_miso_oe = sess;
endmodule

// File: rtl/spi_mem_cmd_if_chk.sv
// Property checker for spi_mem_cmd_if, attached by bind below.
module spi_mem_cmd_if_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic cs_q,
    input logic spi_miso_oe,
    input logic wren_req,
    input logic wrdi_req,
    input logic wr_stage,
    input logic wr_commit,
    input logic wr_cancel,
    input logic sr_wr_req,
    input logic mem_wr_grant,
    input logic sr_wr_grant
);
    assert_oe_off_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && cs_q) |=> !spi_miso_oe);

    assert_single_request_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_req, wrdi_req, wr_stage, wr_commit, wr_cancel, sr_wr_req}));

    assert_latch_pulse_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_req || wrdi_req) |=> !(wren_req || wrdi_req));

    assert_commit_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(mem_wr_grant));

    assert_commit_after_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit || wr_cancel) |-> !spi_miso_oe);

    assert_status_write_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_req |-> $past(sr_wr_grant));
endmodule

bind spi_mem_cmd_if spi_mem_cmd_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_q(cs_q),
    .spi_miso_oe(spi_miso_oe), .wren_req(wren_req), .wrdi_req(wrdi_req),
    .wr_stage(wr_stage), .wr_commit(wr_commit), .wr_cancel(wr_cancel),
    .sr_wr_req(sr_wr_req), .mem_wr_grant(mem_wr_grant), .sr_wr_grant(sr_wr_grant)
);

// File: tb/spi_mem_cmd_if_test.sv
// Scoreboard bench: driver tasks queue expected requests, a monitor compares.
module spi_mem_cmd_if_test;
    localparam int HALF = 8;
    localparam int K_WREN = 1, K_WRDI = 2, K_STAGE = 3, K_COMMIT = 4, K_CANCEL = 5, K_SR = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, spi_sck, spi_cs_n, spi_mosi, spi_miso, spi_miso_oe;
    logic [9:0] mem_addr, wr_addr;
    logic [7:0] mem_rd_data, status_in, wr_data, sr_wr_data;
    logic       mem_wr_grant, sr_wr_grant;
    logic       wren_req, wrdi_req, wr_stage, wr_commit, wr_incr, wr_cancel, sr_wr_req;

    logic [7:0] mem [1024];
    assign mem_rd_data = mem[mem_addr];

    spi_mem_cmd_if uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .status_in(status_in),
        .mem_wr_grant(mem_wr_grant), .sr_wr_grant(sr_wr_grant),
        .wren_req(wren_req), .wrdi_req(wrdi_req), .wr_stage(wr_stage),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .wr_incr(wr_incr), .wr_cancel(wr_cancel), .sr_wr_req(sr_wr_req),
        .sr_wr_data(sr_wr_data)
    );

    typedef struct {
        int    kind;
        int    addr;
        int    data;
        int    incr;
        string tag;
    } ev_t;

    ev_t evq[$];
    int  vectors = 0;
    int  miscompares = 0;
    int  n_ev = 0;
    int  n_wren = 0;
    bit  done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input int addr, input int data, input int incr, input string tag);
        ev_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.incr = incr; e.tag = tag;
        evq.push_back(e);
    endtask

    // Monitor: every request pulse is popped against the expected queue.
    int m_kind, m_addr, m_data, m_incr;
    always @(negedge clk) begin
        if (rst_n && (wren_req | wrdi_req | wr_stage | wr_commit | wr_cancel | sr_wr_req)) begin
            m_addr = 0; m_data = 0; m_incr = 0;
            if (wren_req)       begin m_kind = K_WREN; n_wren++; end
            else if (wrdi_req)  m_kind = K_WRDI;
            else if (wr_stage)  begin m_kind = K_STAGE; m_addr = int'(wr_addr); m_data = int'(wr_data); end
            else if (wr_commit) begin m_kind = K_COMMIT; m_incr = int'(wr_incr); end
            else if (wr_cancel) m_kind = K_CANCEL;
            else                begin m_kind = K_SR; m_data = int'(sr_wr_data); end
            n_ev++;
            if (evq.size() == 0) begin
                check(1'b0, "R3/R13 unexpected request kind", m_kind, 0);
            end else begin
                ev_t e;
                e = evq.pop_front();
                check(e.kind == m_kind, {e.tag, " request kind"}, m_kind, e.kind);
                check(e.addr == m_addr && e.data == m_data && e.incr == m_incr,
                      {e.tag, " request addr/data/incr"},
                      (m_addr << 12) | (m_data << 4) | m_incr,
                      (e.addr << 12) | (e.data << 4) | e.incr);
            end
        end
    end

    task automatic sel(input bit m3);
        @(negedge clk);
        spi_sck = m3;
        repeat (2) @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_sck  = 1'b0;
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i]   = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic desel(input bit m3);
        if (!m3) spi_sck = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic rd_burst(input bit m3, input logic [15:0] a, input int n, input string tag);
        logic [7:0] rx;
        sel(m3);
        xb(8'h03, rx);
        xb(a[15:8], rx);
        xb(a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            xb(8'h00, rx);
            check(rx == mem[(int'(a[9:0]) + k) % 1024], tag, int'(rx), int'(mem[(int'(a[9:0]) + k) % 1024]));
        end
        desel(m3);
    endtask

    // Watchdog: an expired run counts as a miscompare and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        int ev0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
        rst_n = 1'b0; spi_cs_n = 1'b0; spi_sck = 1'b0; spi_mosi = 1'b0;
        status_in = 8'h00; mem_wr_grant = 1'b1; sr_wr_grant = 1'b1;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(spi_miso_oe == 1'b0, "R1 oe after reset", int'(spi_miso_oe), 0);
        check(spi_miso == 1'b0, "R1 miso after reset", int'(spi_miso), 0);
        // R2: chip select low since reset, no fall seen yet
        repeat (4) @(negedge clk);
        xb(8'h06, rx);
        xb(8'h04, rx);
        check(n_ev == 0, "R2 requests before first select", n_ev, 0);
        check(spi_miso_oe == 1'b0, "R2 oe before first select", int'(spi_miso_oe), 0);
        desel(1'b0);
        // R2/R6: proper select then WREN, trailing bits ignored
        push(K_WREN, 0, 0, 0, "R6");
        sel(1'b0);
        xb(8'h06, rx);
        xb(8'h04, rx);
        xb(8'h06, rx);
        desel(1'b0);
        check(n_wren == 1, "R6 single latch-set pulse", n_wren, 1);
        push(K_WRDI, 0, 0, 0, "R6");
        sel(1'b0);
        xb(8'h04, rx);
        xb(8'h03, rx);
        desel(1'b0);
        // R4: sequential read
        rd_burst(1'b0, 16'h0010, 3, "R4 read data");
        // R4: high address bits ignored, wrap at top
        rd_burst(1'b0, 16'hFFFE, 3, "R4 read wrap");
        // R12: idle-high clock polarity
        rd_burst(1'b1, 16'h0123, 2, "R12 mode3 read");
        // R11: oe during and after a transaction
        sel(1'b0);
        xb(8'h03, rx);
        check(spi_miso_oe == 1'b1, "R11 oe while selected", int'(spi_miso_oe), 1);
        desel(1'b0);
        check(spi_miso_oe == 1'b0, "R11 oe after deselect", int'(spi_miso_oe), 0);
        // R5: continuous status polling
        status_in = 8'h03;
        sel(1'b0);
        xb(8'h05, rx);
        xb(8'h00, rx);
        check(rx == 8'h03, "R5 status byte 1", int'(rx), 8'h03);
        status_in = 8'h82;
        xb(8'h00, rx);
        check(rx == 8'h03, "R5 status byte 2 (loaded earlier)", int'(rx), 8'h03);
        xb(8'h00, rx);
        check(rx == 8'h82, "R5 status byte 3", int'(rx), 8'h82);
        xb(8'h00, rx);
        check(rx == 8'h82, "R5 status byte 4", int'(rx), 8'h82);
        desel(1'b0);
        // R7/R8: page-wrapping write with commit
        push(K_STAGE, 10'h03E, 8'hA1, 0, "R7");
        push(K_STAGE, 10'h03F, 8'hB2, 0, "R7");
        push(K_STAGE, 10'h020, 8'hC3, 0, "R7");
        push(K_COMMIT, 0, 0, 0, "R8");
        sel(1'b0);
        xb(8'h02, rx); xb(8'h00, rx); xb(8'h3E, rx);
        xb(8'hA1, rx); xb(8'hB2, rx); xb(8'hC3, rx);
        desel(1'b0);
        // R8: deselect off a byte boundary cancels
        push(K_STAGE, 10'h100, 8'h5A, 0, "R7");
        push(K_CANCEL, 0, 0, 0, "R8");
        sel(1'b0);
        xb(8'h02, rx); xb(8'h01, rx); xb(8'h00, rx); xb(8'h5A, rx);
        xbits(8'hFF, 3, rx);
        desel(1'b0);
        // R8: no grant cancels
        mem_wr_grant = 1'b0;
        push(K_STAGE, 10'h200, 8'h11, 0, "R7");
        push(K_CANCEL, 0, 0, 0, "R8");
        sel(1'b0);
        xb(8'h02, rx); xb(8'h02, rx); xb(8'h00, rx); xb(8'h11, rx);
        desel(1'b0);
        mem_wr_grant = 1'b1;
        // R8: no data byte, no commit and no cancel
        ev0 = n_ev;
        sel(1'b0);
        xb(8'h02, rx); xb(8'h00, rx); xb(8'h40, rx);
        desel(1'b0);
        check(n_ev == ev0, "R8 empty write silent", n_ev - ev0, 0);
        // R9: monotonic-counter write carries incr flag
        push(K_STAGE, 10'h004, 8'h12, 0, "R9");
        push(K_STAGE, 10'h005, 8'h34, 0, "R9");
        push(K_COMMIT, 0, 0, 1, "R9");
        sel(1'b1);
        xb(8'h07, rx); xb(8'h00, rx); xb(8'h04, rx); xb(8'h12, rx); xb(8'h34, rx);
        desel(1'b1);
        // R10: status write takes first byte
        push(K_SR, 0, 8'h8C, 0, "R10");
        sel(1'b0);
        xb(8'h01, rx); xb(8'h8C, rx); xb(8'h11, rx);
        desel(1'b0);
        sr_wr_grant = 1'b0;
        ev0 = n_ev;
        sel(1'b0);
        xb(8'h01, rx); xb(8'h44, rx);
        desel(1'b0);
        check(n_ev == ev0, "R10 status write without grant", n_ev - ev0, 0);
        sr_wr_grant = 1'b1;
        // R3: unknown opcode ignores the rest
        ev0 = n_ev;
        sel(1'b0);
        xb(8'h55, rx);
        xb(8'h06, rx);
        check(rx == 8'h00, "R3 miso after unknown opcode", int'(rx), 0);
        xb(8'h03, rx);
        xb(8'h00, rx);
        check(rx == 8'h00, "R3 miso stays low", int'(rx), 0);
        desel(1'b0);
        check(n_ev == ev0, "R3 no request after unknown opcode", n_ev - ev0, 0);
        // R13: everything expected was seen
        check(evq.size() == 0, "R13 pending expected requests", evq.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule